// File: doc/BRIEF.md
# Per-Thread Squash and Trap Controller

This block tracks the commit-side status of every hardware thread in a multithreaded out-of-order core. It decides when a thread's speculative work must be thrown away, and it broadcasts that decision to the rest of the pipeline. Each thread is in one of five states: Idle, Running, buffer-squashing, trap-pending or fetch-trap-pending. Three sources can ask for a squash: the execute stage, a trap raised at commit, and an external context-change request. When a squash is accepted, the block emits a one-cycle squash pulse. The pulse carries a boundary sequence number, a redirect address triple (PC, next PC, next micro-PC) and the branch mispredict and taken flags.

For each thread the block keeps a youngest-valid sequence number. An execute-stage squash is accepted only when it is not younger than that value, so a late, younger squash can never override an older one already in progress. A trap does not squash at once. It arms a per-thread countdown whose length comes from a programmable latency input, and the squash is performed in the cycle after the countdown ends. The reorder buffer itself lives outside the block. The buffer supplies its head sequence number, an empty flag and a done-squashing strobe, and the block reports a one-cycle done pulse when a thread leaves the squashing state.

Top module: `sqt_ctrl`

## Requirements
- R1: After reset every thread reports state Idle (code 0), with no squash pulse, no buffer-squashing flag, no trap in flight, youngest sequence 0 and a mispredict count of 0.
- R2: A dispatch to a thread sets that thread's youngest sequence number to the dispatched value. A thread in Idle moves to Running (code 1) on that dispatch.
- R3: An execute squash is accepted only when its sequence number is less than or equal to the thread's youngest sequence number and the thread is not in a trap state (code 3 or 4). A rejected request changes no output and no state.
- R4: An accepted execute squash produces, one cycle later: a squash pulse, a boundary equal to the squashed sequence number (minus one when the include bit is set), a youngest sequence number equal to that boundary, state buffer-squashing (code 2), and the forwarded mispredict, taken and redirect fields.
- R5: A thread in buffer-squashing holds its buffer-squashing output high every cycle until the buffer reports done. It then moves to Running, and the done output pulses for one cycle.
- R6: A trap request moves a Running or Idle thread to trap-pending (code 3), and a fetch-trap request moves it to code 4. Both set trap-in-flight. With latency L (0 counts as 1), the squash pulse appears exactly L+1 cycles after the request is sampled, and never earlier.
- R7: A trap or context-change squash uses boundary head-minus-one, or 0 when the buffer is empty. It clears the youngest sequence number to 0, redirects to the last committed PC triple, and clears the mispredict and taken flags.
- R8: Performing a trap squash clears trap-in-flight for that thread in the same cycle that the squash pulse appears.
- R9: When a trap and a context-change request are pending together, the trap squash is performed first. The context-change squash is held while the trap is in flight and is performed in the following cycle.
- R10: The mispredict counter advances by one for each accepted execute squash that carries the mispredict flag, and by nothing otherwise.
- R11: Requests to one thread leave every other thread's state, youngest sequence number and squash outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_lat | input | LAT_W | Trap-to-squash latency in cycles |
| disp_vld | input | NTHR | Dispatch strobe per thread |
| disp_seq | input | NTHR*SEQ_W | Dispatched sequence number per thread |
| cmt_vld | input | NTHR | Commit strobe per thread; captures the restart triple |
| cmt_pc | input | NTHR*PC_W | Restart PC after commit |
| cmt_npc | input | NTHR*PC_W | Restart next PC after commit |
| cmt_upc | input | NTHR*UPC_W | Restart micro-PC after commit |
| rob_empty | input | NTHR | Reorder buffer empty per thread |
| rob_head_seq | input | NTHR*SEQ_W | Sequence number at buffer head |
| rob_sq_done | input | NTHR | Buffer finished squashing |
| ex_sq_vld | input | NTHR | Execute squash request |
| ex_sq_seq | input | NTHR*SEQ_W | Squashing sequence number |
| ex_sq_incl | input | NTHR | Include the squashing instruction |
| ex_sq_mispred | input | NTHR | Request is a branch mispredict |
| ex_sq_taken | input | NTHR | Branch was taken |
| ex_sq_pc | input | NTHR*PC_W | Redirect PC |
| ex_sq_npc | input | NTHR*PC_W | Redirect next PC |
| ex_sq_upc | input | NTHR*UPC_W | Redirect micro-PC |
| trap_req | input | NTHR | Commit-side trap request |
| ftrap_req | input | NTHR | Fetch-side trap request |
| ctx_req | input | NTHR | External context-change squash request |
| thr_status | output | NTHR*3 | Thread state code |
| sq_out | output | NTHR | Squash pulse |
| robsq_out | output | NTHR | Buffer-squashing in progress |
| sq_bound | output | NTHR*SEQ_W | Squash boundary sequence number |
| sq_mispred | output | NTHR | Mispredict flag of last squash |
| sq_taken | output | NTHR | Taken flag of last squash |
| rd_pc | output | NTHR*PC_W | Redirect PC |
| rd_npc | output | NTHR*PC_W | Redirect next PC |
| rd_upc | output | NTHR*UPC_W | Redirect micro-PC |
| youngest_seq | output | NTHR*SEQ_W | Youngest valid sequence number |
| trap_inflight | output | NTHR | Trap countdown armed or pending |
| sq_done | output | NTHR | One-cycle pulse when squashing ends |
| mispred_cnt | output | CNT_W | Accepted mispredict squash count |

## Verification
The bench first squashes and then sends a younger request, which must be dropped; a design that compared in the wrong direction would let the younger squash overwrite the older boundary. It sends an older squash with the include bit set, to catch an off-by-one in the boundary. It counts the cycles of the trap countdown exactly, so a timer that fires one cycle early or late shows up as a pulse in the wrong cycle. It also sends an otherwise acceptable execute squash during trap-pending, which a missing state filter would accept. Finally it raises a trap and a context-change request together on an empty buffer and expects two squash pulses in a fixed order with boundary 0; a design without the priority rule would lose one of them or let the context-change squash go first.

// File: rtl/sqt_pkg.sv
package sqt_pkg;
   localparam int ST_W = 3;

   typedef enum logic [ST_W-1:0] {
      ST_IDLE  = 3'd0,
      ST_RUN   = 3'd1,
      ST_ROBSQ = 3'd2,
      ST_TRAP  = 3'd3,
      ST_FTRAP = 3'd4
   } thr_st_e;
endpackage

// File: rtl/sqt_trap_timer.sv
module sqt_trap_timer #(
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LAT_W-1:0] lat,
   input  logic             start,
   input  logic             clear,
   output logic             busy,
   output logic             fire
);
   logic [LAT_W-1:0] cnt_q;
   logic [LAT_W-1:0] load_val;

   // a zero latency is stretched to one cycle
   assign load_val = (lat == '0) ? LAT_W'(1) : lat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         busy  <= 1'b0;
         fire  <= 1'b0;
      end else if (clear) begin
         cnt_q <= '0;
         busy  <= 1'b0;
         fire  <= 1'b0;
      end else if (start) begin
         cnt_q <= load_val;
         busy  <= 1'b1;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - LAT_W'(1);
         if (cnt_q == LAT_W'(1))
            fire <= 1'b1;
      end
   end

   // R6
   start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy && !fire);

   // R6
   fire_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fire) |-> $past(busy));
endmodule

// File: rtl/sqt_evt_cnt.sv
module sqt_evt_cnt #(
   parameter int NIN   = 2,
   parameter int CNT_W = 16,
   parameter bit SAT   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NIN-1:0]   evt,
   output logic [CNT_W-1:0] cnt_o
);
   localparam int INC_W = $clog2(NIN + 1);

   logic [INC_W-1:0] inc;
   logic [CNT_W:0]   sum;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      inc = '0;
      for (int i = 0; i < NIN; i++)
         inc = inc + INC_W'(evt[i]);
   end

   assign sum = {1'b0, cnt_o} + (CNT_W+1)'(inc);

   generate
      if (SAT) begin : g_sat
         assign nxt = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
      end else begin : g_wrap
         assign nxt = sum[CNT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_o <= '0;
      else        cnt_o <= nxt;
   end

   // R10
   cnt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o != $past(cnt_o)) |-> ($past(inc) != '0));
endmodule

// File: rtl/sqt_thread.sv
module sqt_thread
   import sqt_pkg::*;
#(
   parameter int SEQ_W = 16,
   parameter int PC_W  = 32,
   parameter int UPC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             disp_vld,
   input  logic [SEQ_W-1:0] disp_seq,
   input  logic             cmt_vld,
   input  logic [PC_W-1:0]  cmt_pc,
   input  logic [PC_W-1:0]  cmt_npc,
   input  logic [UPC_W-1:0] cmt_upc,
   input  logic             rob_empty,
   input  logic [SEQ_W-1:0] rob_head_seq,
   input  logic             rob_sq_done,
   input  logic             ex_vld,
   input  logic [SEQ_W-1:0] ex_seq,
   input  logic             ex_incl,
   input  logic             ex_mp,
   input  logic             ex_tk,
   input  logic [PC_W-1:0]  ex_pc,
   input  logic [PC_W-1:0]  ex_npc,
   input  logic [UPC_W-1:0] ex_upc,
   input  logic             trap_req,
   input  logic             ftrap_req,
   input  logic             ctx_req,
   input  logic             trap_busy,
   input  logic             trap_fire,
   output logic             trap_start,
   output logic             trap_clear,
   output logic [ST_W-1:0]  state_o,
   output logic             sq_o,
   output logic             robsq_o,
   output logic [SEQ_W-1:0] bound_o,
   output logic             mp_o,
   output logic             tk_o,
   output logic [PC_W-1:0]  pc_o,
   output logic [PC_W-1:0]  npc_o,
   output logic [UPC_W-1:0] upc_o,
   output logic [SEQ_W-1:0] youngest_o,
   output logic             done_o,
   output logic             mp_evt_o
);
   thr_st_e          state_q, state_d;
   logic [SEQ_W-1:0] youngest_q;
   logic [PC_W-1:0]  sv_pc_q, sv_npc_q;
   logic [UPC_W-1:0] sv_upc_q;
   logic             ctx_pend_q;

   logic             do_trap_sq, do_ctx_sq, sq_all, in_trap, ex_ok, run_ok;
   logic [SEQ_W-1:0] ex_bound, all_bound;

   assign in_trap    = (state_q == ST_TRAP) || (state_q == ST_FTRAP);
   assign run_ok     = (state_q == ST_RUN) || (state_q == ST_IDLE);

   // trap squash wins; a context change waits for the trap to clear
   assign do_trap_sq = trap_fire;
   assign do_ctx_sq  = ctx_pend_q && !trap_fire && !trap_busy;
   assign sq_all     = do_trap_sq || do_ctx_sq;

   // age filter against the youngest valid sequence number
   assign ex_ok      = ex_vld && !in_trap && !sq_all && (ex_seq <= youngest_q);
   assign ex_bound   = ex_incl ? (ex_seq - SEQ_W'(1)) : ex_seq;
   assign all_bound  = rob_empty ? '0 : (rob_head_seq - SEQ_W'(1));

   assign trap_start = (trap_req || ftrap_req) && run_ok && !trap_busy
                       && !sq_all && !ex_ok;
   assign trap_clear = do_trap_sq;
   assign mp_evt_o   = ex_ok && ex_mp;

   always_comb begin
      state_d = state_q;
      if (sq_all || ex_ok)
         state_d = ST_ROBSQ;
      else if (trap_start)
         state_d = trap_req ? ST_TRAP : ST_FTRAP;
      else begin
         case (state_q)
            ST_IDLE:  if (disp_vld)    state_d = ST_RUN;
            ST_ROBSQ: if (rob_sq_done) state_d = ST_RUN;
            default:  state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         youngest_q <= '0;
         sv_pc_q    <= '0;
         sv_npc_q   <= '0;
         sv_upc_q   <= '0;
         ctx_pend_q <= 1'b0;
         sq_o       <= 1'b0;
         bound_o    <= '0;
         mp_o       <= 1'b0;
         tk_o       <= 1'b0;
         pc_o       <= '0;
         npc_o      <= '0;
         upc_o      <= '0;
         done_o     <= 1'b0;
      end else begin
         state_q    <= state_d;
         ctx_pend_q <= (ctx_pend_q && !do_ctx_sq) || ctx_req;
         sq_o       <= sq_all || ex_ok;
         done_o     <= (state_q == ST_ROBSQ) && rob_sq_done && !sq_all && !ex_ok;

         if (cmt_vld) begin
            sv_pc_q  <= cmt_pc;
            sv_npc_q <= cmt_npc;
            sv_upc_q <= cmt_upc;
         end

         if (sq_all) begin
            youngest_q <= '0;
            bound_o    <= all_bound;
            mp_o       <= 1'b0;
            tk_o       <= 1'b0;
            pc_o       <= sv_pc_q;
            npc_o      <= sv_npc_q;
            upc_o      <= sv_upc_q;
         end else if (ex_ok) begin
            youngest_q <= ex_bound;
            bound_o    <= ex_bound;
            mp_o       <= ex_mp;
            tk_o       <= ex_tk;
            pc_o       <= ex_pc;
            npc_o      <= ex_npc;
            upc_o      <= ex_upc;
         end else if (disp_vld) begin
            youngest_q <= disp_seq;
         end
      end
   end

   assign state_o    = state_q;
   assign robsq_o    = (state_q == ST_ROBSQ);
   assign youngest_o = youngest_q;

   // R4
   sq_robsq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sq_o |-> robsq_o);

   // R5
   robsq_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == ST_ROBSQ && state_q == ST_RUN) |-> $past(rob_sq_done));

   // R3
   trap_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_vld && in_trap && !trap_fire && !disp_vld) |=> youngest_q == $past(youngest_q));

   // R8
   trap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_fire |=> sq_o && !trap_busy);
endmodule

// File: rtl/sqt_ctrl.sv
module sqt_ctrl
   import sqt_pkg::*;
#(
   parameter int NTHR    = 2,
   parameter int SEQ_W   = 16,
   parameter int PC_W    = 32,
   parameter int UPC_W   = 8,
   parameter int LAT_W   = 8,
   parameter int CNT_W   = 16,
   parameter bit CNT_SAT = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LAT_W-1:0]        trap_lat,
   input  logic [NTHR-1:0]         disp_vld,
   input  logic [NTHR*SEQ_W-1:0]   disp_seq,
   input  logic [NTHR-1:0]         cmt_vld,
   input  logic [NTHR*PC_W-1:0]    cmt_pc,
   input  logic [NTHR*PC_W-1:0]    cmt_npc,
   input  logic [NTHR*UPC_W-1:0]   cmt_upc,
   input  logic [NTHR-1:0]         rob_empty,
   input  logic [NTHR*SEQ_W-1:0]   rob_head_seq,
   input  logic [NTHR-1:0]         rob_sq_done,
   input  logic [NTHR-1:0]         ex_sq_vld,
   input  logic [NTHR*SEQ_W-1:0]   ex_sq_seq,
   input  logic [NTHR-1:0]         ex_sq_incl,
   input  logic [NTHR-1:0]         ex_sq_mispred,
   input  logic [NTHR-1:0]         ex_sq_taken,
   input  logic [NTHR*PC_W-1:0]    ex_sq_pc,
   input  logic [NTHR*PC_W-1:0]    ex_sq_npc,
   input  logic [NTHR*UPC_W-1:0]   ex_sq_upc,
   input  logic [NTHR-1:0]         trap_req,
   input  logic [NTHR-1:0]         ftrap_req,
   input  logic [NTHR-1:0]         ctx_req,
   output logic [NTHR*ST_W-1:0]    thr_status,
   output logic [NTHR-1:0]         sq_out,
   output logic [NTHR-1:0]         robsq_out,
   output logic [NTHR*SEQ_W-1:0]   sq_bound,
   output logic [NTHR-1:0]         sq_mispred,
   output logic [NTHR-1:0]         sq_taken,
   output logic [NTHR*PC_W-1:0]    rd_pc,
   output logic [NTHR*PC_W-1:0]    rd_npc,
   output logic [NTHR*UPC_W-1:0]   rd_upc,
   output logic [NTHR*SEQ_W-1:0]   youngest_seq,
   output logic [NTHR-1:0]         trap_inflight,
   output logic [NTHR-1:0]         sq_done,
   output logic [CNT_W-1:0]        mispred_cnt
);
   initial begin
      assert (NTHR >= 1 && NTHR <= 64);
      assert (SEQ_W >= 2);
      assert (PC_W >= 1 && UPC_W >= 1);
      assert (LAT_W >= 1 && LAT_W <= 32);
      assert (CNT_W >= $clog2(NTHR + 1));
   end

   logic [NTHR-1:0] t_start, t_clear, t_busy, t_fire, mp_evt;

   generate
      for (genvar t = 0; t < NTHR; t++) begin : g_thr
         sqt_trap_timer #(.LAT_W(LAT_W)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .lat   (trap_lat),
            .start (t_start[t]),
            .clear (t_clear[t]),
            .busy  (t_busy[t]),
            .fire  (t_fire[t])
         );

         sqt_thread #(.SEQ_W(SEQ_W), .PC_W(PC_W), .UPC_W(UPC_W)) u_thr (
            .clk          (clk),
            .rst_n        (rst_n),
            .disp_vld     (disp_vld[t]),
            .disp_seq     (disp_seq[t*SEQ_W +: SEQ_W]),
            .cmt_vld      (cmt_vld[t]),
            .cmt_pc       (cmt_pc[t*PC_W +: PC_W]),
            .cmt_npc      (cmt_npc[t*PC_W +: PC_W]),
            .cmt_upc      (cmt_upc[t*UPC_W +: UPC_W]),
            .rob_empty    (rob_empty[t]),
            .rob_head_seq (rob_head_seq[t*SEQ_W +: SEQ_W]),
            .rob_sq_done  (rob_sq_done[t]),
            .ex_vld       (ex_sq_vld[t]),
            .ex_seq       (ex_sq_seq[t*SEQ_W +: SEQ_W]),
            .ex_incl      (ex_sq_incl[t]),
            .ex_mp        (ex_sq_mispred[t]),
            .ex_tk        (ex_sq_taken[t]),
            .ex_pc        (ex_sq_pc[t*PC_W +: PC_W]),
            .ex_npc       (ex_sq_npc[t*PC_W +: PC_W]),
            .ex_upc       (ex_sq_upc[t*UPC_W +: UPC_W]),
            .trap_req     (trap_req[t]),
            .ftrap_req    (ftrap_req[t]),
            .ctx_req      (ctx_req[t]),
            .trap_busy    (t_busy[t]),
            .trap_fire    (t_fire[t]),
            .trap_start   (t_start[t]),
            .trap_clear   (t_clear[t]),
            .state_o      (thr_status[t*ST_W +: ST_W]),
            .sq_o         (sq_out[t]),
            .robsq_o      (robsq_out[t]),
            .bound_o      (sq_bound[t*SEQ_W +: SEQ_W]),
            .mp_o         (sq_mispred[t]),
            .tk_o         (sq_taken[t]),
            .pc_o         (rd_pc[t*PC_W +: PC_W]),
            .npc_o        (rd_npc[t*PC_W +: PC_W]),
            .upc_o        (rd_upc[t*UPC_W +: UPC_W]),
            .youngest_o   (youngest_seq[t*SEQ_W +: SEQ_W]),
            .done_o       (sq_done[t]),
            .mp_evt_o     (mp_evt[t])
         );

         // R9
         prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(t_busy[t]) |-> sq_out[t]);
      end
   endgenerate

   assign trap_inflight = t_busy;

   sqt_evt_cnt #(.NIN(NTHR), .CNT_W(CNT_W), .SAT(CNT_SAT)) u_mpcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (mp_evt),
      .cnt_o (mispred_cnt)
   );

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> (sq_out == '0 && trap_inflight == '0));
endmodule

// File: tb/sqt_ctrl_tb.sv
`timescale 1ns/1ps
module sqt_ctrl_tb;
   localparam int NT = 2, SW = 16, PW = 32, UW = 8, LW = 8, CW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [LW-1:0]    trap_lat = '0;
   logic [NT-1:0]    disp_vld = '0, cmt_vld = '0, rob_empty = '0, rob_sq_done = '0;
   logic [NT*SW-1:0] disp_seq = '0, rob_head_seq = '0, ex_sq_seq = '0;
   logic [NT*PW-1:0] cmt_pc = '0, cmt_npc = '0, ex_sq_pc = '0, ex_sq_npc = '0;
   logic [NT*UW-1:0] cmt_upc = '0, ex_sq_upc = '0;
   logic [NT-1:0]    ex_sq_vld = '0, ex_sq_incl = '0, ex_sq_mispred = '0, ex_sq_taken = '0;
   logic [NT-1:0]    trap_req = '0, ftrap_req = '0, ctx_req = '0;
   logic [NT*3-1:0]  thr_status;
   logic [NT-1:0]    sq_out, robsq_out, sq_mispred, sq_taken, trap_inflight, sq_done;
   logic [NT*SW-1:0] sq_bound, youngest_seq;
   logic [NT*PW-1:0] rd_pc, rd_npc;
   logic [NT*UW-1:0] rd_upc;
   logic [CW-1:0]    mispred_cnt;

   int n_chk = 0, n_fail = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   sqt_ctrl #(.NTHR(NT), .SEQ_W(SW), .PC_W(PW), .UPC_W(UW), .LAT_W(LW), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .trap_lat(trap_lat),
      .disp_vld(disp_vld), .disp_seq(disp_seq),
      .cmt_vld(cmt_vld), .cmt_pc(cmt_pc), .cmt_npc(cmt_npc), .cmt_upc(cmt_upc),
      .rob_empty(rob_empty), .rob_head_seq(rob_head_seq), .rob_sq_done(rob_sq_done),
      .ex_sq_vld(ex_sq_vld), .ex_sq_seq(ex_sq_seq), .ex_sq_incl(ex_sq_incl),
      .ex_sq_mispred(ex_sq_mispred), .ex_sq_taken(ex_sq_taken),
      .ex_sq_pc(ex_sq_pc), .ex_sq_npc(ex_sq_npc), .ex_sq_upc(ex_sq_upc),
      .trap_req(trap_req), .ftrap_req(ftrap_req), .ctx_req(ctx_req),
      .thr_status(thr_status), .sq_out(sq_out), .robsq_out(robsq_out),
      .sq_bound(sq_bound), .sq_mispred(sq_mispred), .sq_taken(sq_taken),
      .rd_pc(rd_pc), .rd_npc(rd_npc), .rd_upc(rd_upc),
      .youngest_seq(youngest_seq), .trap_inflight(trap_inflight),
      .sq_done(sq_done), .mispred_cnt(mispred_cnt)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [2:0]  st(input int t);  return thr_status[t*3 +: 3];   endfunction
   function automatic logic [SW-1:0] yng(input int t); return youngest_seq[t*SW +: SW]; endfunction
   function automatic logic [SW-1:0] bnd(input int t); return sq_bound[t*SW +: SW];    endfunction

   task automatic ex_squash(input int t, input logic [SW-1:0] s, input logic incl,
                            input logic mp, input logic tk, input logic [PW-1:0] pc);
      ex_sq_vld[t] = 1'b1;
      ex_sq_seq[t*SW +: SW] = s;
      ex_sq_incl[t] = incl;
      ex_sq_mispred[t] = mp;
      ex_sq_taken[t] = tk;
      ex_sq_pc[t*PW +: PW] = pc;
      ex_sq_npc[t*PW +: PW] = pc + 32'd4;
      ex_sq_upc[t*UW +: UW] = 8'd3;
      tick();
      ex_sq_vld = '0;
      ex_sq_incl = '0;
      ex_sq_mispred = '0;
      ex_sq_taken = '0;
   endtask

   task automatic finish_squash(input int t);
      rob_sq_done[t] = 1'b1;
      tick();
      rob_sq_done = '0;
   endtask

   task automatic t_reset();
      for (int t = 0; t < NT; t++) begin
         chk("R1 state", st(t), 3'd0);
         chk("R1 youngest", yng(t), '0);
      end
      chk("R1 squash", {sq_out, robsq_out, trap_inflight}, '0);
      chk("R1 counter", mispred_cnt, '0);
   endtask

   task automatic t_dispatch();
      disp_vld = 2'b11;
      disp_seq = {16'd200, 16'd100};
      tick();
      disp_vld = '0;
      chk("R2 state t0", st(0), 3'd1);
      chk("R2 state t1", st(1), 3'd1);
      chk("R2 youngest t0", yng(0), 16'd100);
      chk("R2 youngest t1", yng(1), 16'd200);
   endtask

   task automatic t_exec();
      ex_squash(0, 16'd50, 1'b0, 1'b1, 1'b1, 32'h2000);
      chk("R4 pulse", sq_out, 2'b01);
      chk("R4 bound", bnd(0), 16'd50);
      chk("R4 youngest", yng(0), 16'd50);
      chk("R4 state", st(0), 3'd2);
      chk("R4 robsq", robsq_out[0], 1'b1);
      chk("R4 flags", {sq_mispred[0], sq_taken[0]}, 2'b11);
      chk("R4 pc", rd_pc[31:0], 32'h2000);
      chk("R4 npc", rd_npc[31:0], 32'h2004);
      chk("R4 upc", rd_upc[7:0], 8'd3);
      chk("R10 count", mispred_cnt, 16'd1);
      chk("R11 other youngest", yng(1), 16'd200);
      chk("R11 other state", st(1), 3'd1);
      // younger request must be dropped
      ex_squash(0, 16'd60, 1'b0, 1'b1, 1'b0, 32'h3000);
      chk("R3 younger pulse", sq_out[0], 1'b0);
      chk("R3 younger youngest", yng(0), 16'd50);
      chk("R3 younger pc", rd_pc[31:0], 32'h2000);
      chk("R10 no count", mispred_cnt, 16'd1);
      // older request with include bit
      ex_squash(0, 16'd40, 1'b1, 1'b0, 1'b0, 32'h4000);
      chk("R4 incl pulse", sq_out[0], 1'b1);
      chk("R4 incl bound", bnd(0), 16'd39);
      chk("R4 incl youngest", yng(0), 16'd39);
      chk("R4 incl taken", sq_taken[0], 1'b0);
      chk("R10 plain squash", mispred_cnt, 16'd1);
   endtask

   task automatic t_robsq();
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R5 hold robsq", robsq_out[0], 1'b1);
         chk("R5 hold state", st(0), 3'd2);
      end
      finish_squash(0);
      chk("R5 state run", st(0), 3'd1);
      chk("R5 robsq low", robsq_out[0], 1'b0);
      chk("R5 done pulse", sq_done[0], 1'b1);
      tick();
      chk("R5 done one cycle", sq_done[0], 1'b0);
   endtask

   task automatic t_trap();
      trap_lat = 8'd4;
      cmt_vld[0] = 1'b1;
      cmt_pc[31:0] = 32'h1000;
      cmt_npc[31:0] = 32'h1004;
      cmt_upc[7:0] = 8'h07;
      rob_empty[0] = 1'b0;
      rob_head_seq[15:0] = 16'd30;
      tick();
      cmt_vld = '0;
      trap_req[0] = 1'b1;
      tick();
      trap_req = '0;
      chk("R6 trap state", st(0), 3'd3);
      chk("R6 inflight", trap_inflight[0], 1'b1);
      // an acceptable-looking squash during trap pending
      ex_squash(0, 16'd5, 1'b0, 1'b1, 1'b0, 32'h5000);
      chk("R3 trap blocks pulse", sq_out[0], 1'b0);
      chk("R3 trap blocks youngest", yng(0), 16'd39);
      chk("R10 trap blocks count", mispred_cnt, 16'd1);
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R6 no early squash", sq_out[0], 1'b0);
      end
      tick();
      chk("R6 squash at L+1", sq_out[0], 1'b1);
      chk("R7 bound head-1", bnd(0), 16'd29);
      chk("R7 youngest zero", yng(0), 16'd0);
      chk("R7 pc", rd_pc[31:0], 32'h1000);
      chk("R7 npc", rd_npc[31:0], 32'h1004);
      chk("R7 upc", rd_upc[7:0], 8'h07);
      chk("R7 flags clear", {sq_mispred[0], sq_taken[0]}, 2'b00);
      chk("R8 inflight clear", trap_inflight[0], 1'b0);
      chk("R11 other state", st(1), 3'd1);
      finish_squash(0);
   endtask

   task automatic t_prio();
      trap_lat = 8'd3;
      rob_empty[1] = 1'b1;
      trap_req[1] = 1'b1;
      tick();
      trap_req = '0;
      chk("R6 trap state t1", st(1), 3'd3);
      ctx_req[1] = 1'b1;
      tick();
      ctx_req = '0;
      chk("R9 ctx waits", sq_out[1], 1'b0);
      tick();
      chk("R9 ctx waits 2", sq_out[1], 1'b0);
      tick();
      chk("R9 ctx waits 3", sq_out[1], 1'b0);
      tick();
      chk("R9 trap first", sq_out[1], 1'b1);
      chk("R8 inflight cleared", trap_inflight[1], 1'b0);
      chk("R7 empty bound", bnd(1), 16'd0);
      tick();
      chk("R9 ctx second", sq_out[1], 1'b1);
      chk("R9 state", st(1), 3'd2);
      chk("R7 ctx youngest", yng(1), 16'd0);
      tick();
      chk("R9 no third pulse", sq_out[1], 1'b0);
      chk("R11 other quiet", sq_out[0], 1'b0);
      finish_squash(1);
   endtask

   task automatic t_ftrap();
      trap_lat = 8'd0;
      rob_empty[1] = 1'b0;
      rob_head_seq[31:16] = 16'h0080;
      ftrap_req[1] = 1'b1;
      tick();
      ftrap_req = '0;
      chk("R6 ftrap state", st(1), 3'd4);
      chk("R6 ftrap inflight", trap_inflight[1], 1'b1);
      tick();
      chk("R6 zero latency wait", sq_out[1], 1'b0);
      tick();
      chk("R6 zero latency squash", sq_out[1], 1'b1);
      chk("R7 ftrap bound", bnd(1), 16'h007f);
      finish_squash(1);
      chk("R5 ftrap run", st(1), 3'd1);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_dispatch();
      t_exec();
      t_robsq();
      t_trap();
      t_prio();
      t_ftrap();
      chk("R10 final count", mispred_cnt, 16'd1);
      done_flag = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         report();
         $finish;
      end
   end
endmodule